// File: doc/BRIEF.md
# Aligned 64-Byte Direct-Store Copy Engine

This block copies one 64-byte block from an arbitrary source byte address to a destination byte address that must sit on a line boundary. A command carries both addresses and a lock-request bit. The engine gathers the source through a narrow 64-bit read port, one outstanding word read at a time. The source may start at any byte, so the engine reads eight or nine aligned words and shifts them into a 512-bit staging register. Before it writes, it asks a cache-maintenance port to write back any dirty copy of the destination line and invalidate it, and it waits for the acknowledgement. It then sends the whole line as one undivided 512-bit write beat with every byte enabled and the allocate hint held low.

Each command ends with a one-cycle done pulse and a two-bit status. A set lock bit or a misaligned destination ends the command at once, with no memory traffic. No other flags or status exist.

The command port, the read request port and the write port use valid/ready. The engine holds each valid and its payload until ready is seen. Read responses and the flush acknowledgement are plain single-cycle strobes that the engine always accepts.

Top module: `dline_copy`

## Requirements
- R1: cmd_ready is high only while the engine is idle. A command is taken on a cycle where cmd_valid and cmd_ready are both high. cmd_ready then stays low until the cycle after done.
- R2: If cmd_lock is 0 and any of cmd_dst[5:0] is non-zero, the command ends with status 1 (general fault). No read request, flush request or write is issued.
- R3: If cmd_lock is 1, the command ends with status 2 (illegal operation) and no memory traffic. This check takes priority over the alignment check.
- R4: Source reads are 64-bit word reads at 8-byte-aligned addresses. They rise in steps of 8, starting from cmd_src with its low three bits cleared. There are 8 reads when cmd_src[2:0] is 0 and 9 otherwise. At most one read is outstanding.
- R5: Byte k of wr_data (bits 8k+7:8k) equals the source byte at cmd_src+k. Byte j of a read response word (bits 8j+7:8j) is the byte at address rd_req_addr+j.
- R6: After the last read, flush_req rises with flush_addr equal to the destination. It stays high until flush_ack, and wr_valid does not rise before flush_ack has been seen.
- R7: A successful command issues exactly one write beat. That beat has wr_addr equal to the destination, wr_be all ones and wr_alloc 0.
- R8: rd_req_valid with rd_req_addr, and wr_valid with wr_addr and wr_data, stay unchanged while the matching ready is low.
- R9: done is a single-cycle pulse, one per command. status is valid while done is high and reads 0 on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_src | input | 48 | Source byte address |
| cmd_dst | input | 48 | Destination byte address |
| cmd_lock | input | 1 | Lock request, makes the command illegal |
| rd_req_valid | output | 1 | Word read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 48 | 8-byte-aligned read address |
| rd_rsp_valid | input | 1 | Read data strobe |
| rd_rsp_data | input | 64 | Read data, little-endian |
| flush_req | output | 1 | Write back and invalidate request |
| flush_addr | output | 48 | Line address to flush |
| flush_ack | input | 1 | Flush complete strobe |
| wr_valid | output | 1 | Line write valid |
| wr_ready | input | 1 | Line write accepted |
| wr_addr | output | 48 | Destination line address |
| wr_data | output | 512 | Line data |
| wr_be | output | 64 | Byte enables, all ones |
| wr_alloc | output | 1 | Allocate hint, always 0 |
| done | output | 1 | Command complete pulse |
| status | output | 2 | 0 ok, 1 general fault, 2 illegal |

## Verification
The embedded properties check on every cycle that valid and payload stay held under back-pressure and that flush_req stays up until it is acknowledged. They also check that the write never rises without a prior acknowledgement, that request phases never overlap, that the write address is always line aligned, and that done pulses once and is followed by cmd_ready. Only the directed scenarios can show the rest: the byte-exact shifted data for several source offsets, the read count and address sequence, the flushed address, the single write beat, and the lock and alignment faults, including their priority and the absence of any traffic.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [1:0] {
    CPY_OK  = 2'd0,
    CPY_GPF = 2'd1,
    CPY_ILL = 2'd2
  } cpy_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RREQ,
    S_RWAIT,
    S_FLUSH,
    S_WRITE,
    S_DONE
  } cpy_state_e;
endpackage

// File: rtl/dlc_gather.sv
module dlc_gather #(
  parameter int WORD_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          push,
  input  logic [WORD_W-1:0]             push_data,
  input  logic [$clog2(WORD_W/8)-1:0]   byte_off,
  input  logic                          stage_ld,
  output logic [LINE_BYTES*8-1:0]       line
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int SLOTS      = WORDS + 1;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int IDX_W      = $clog2(SLOTS + 1);

  logic [IDX_W-1:0]        idx_q;
  logic [SLOTS*WORD_W-1:0] flat;
  logic [OFF_W+2:0]        shamt;
  logic [LINE_W-1:0]       shifted;
  logic [LINE_W-1:0]       stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) idx_q <= '0;
    else if (push)       idx_q <= idx_q + 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               w_q <= '0;
      else if (clear)                           w_q <= '0;
      else if (push && idx_q == IDX_W'(g))      w_q <= push_data;
    end
    assign flat[g*WORD_W +: WORD_W] = w_q;
  end

  assign shamt   = {byte_off, 3'b000};
  assign shifted = LINE_W'(flat >> shamt);

  always_ff @(posedge clk) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_ld) stage_q <= shifted;
  end

  assign line = stage_q;

  AST_PUSH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> idx_q < IDX_W'(SLOTS)) else $error("push beyond slots"); // R4
endmodule

// File: rtl/dlc_ctrl.sv
module dlc_ctrl
  import dlc_pkg::*;
#(
  parameter int AW         = 48,
  parameter int WORD_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [AW-1:0]                cmd_src,
  input  logic [AW-1:0]                cmd_dst,
  input  logic                         cmd_lock,
  output logic                         rd_req_valid,
  input  logic                         rd_req_ready,
  output logic [AW-1:0]                rd_req_addr,
  input  logic                         rd_rsp_valid,
  output logic                         flush_req,
  input  logic                         flush_ack,
  output logic                         wr_valid,
  input  logic                         wr_ready,
  output logic [AW-1:0]                dst_addr,
  output logic [$clog2(WORD_W/8)-1:0]  src_off,
  output logic                         g_clear,
  output logic                         g_push,
  output logic                         g_stage,
  output logic                         done,
  output logic [1:0]                   status
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int LOFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(WORDS + 2);

  cpy_state_e        state_q;
  cpy_status_e       stat_q;
  logic [AW-1:0]     base_q;
  logic [AW-1:0]     dst_q;
  logic [OFF_W-1:0]  off_q;
  logic [IDX_W-1:0]  need_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              take;
  logic              last_word;

  assign take      = cmd_valid && cmd_ready;
  assign last_word = rd_rsp_valid && (cnt_q == need_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      stat_q  <= CPY_OK;
      base_q  <= '0;
      dst_q   <= '0;
      off_q   <= '0;
      need_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (take) begin
          base_q <= {cmd_src[AW-1:OFF_W], {OFF_W{1'b0}}};
          off_q  <= cmd_src[OFF_W-1:0];
          dst_q  <= cmd_dst;
          cnt_q  <= '0;
          need_q <= (cmd_src[OFF_W-1:0] != '0) ? IDX_W'(WORDS + 1) : IDX_W'(WORDS);
          if (cmd_lock) begin
            stat_q  <= CPY_ILL;
            state_q <= S_DONE;
          end else if (cmd_dst[LOFF_W-1:0] != '0) begin
            stat_q  <= CPY_GPF;
            state_q <= S_DONE;
          end else begin
            stat_q  <= CPY_OK;
            state_q <= S_RREQ;
          end
        end
        S_RREQ:  if (rd_req_ready) state_q <= S_RWAIT;
        S_RWAIT: if (rd_rsp_valid) begin
          cnt_q   <= cnt_q + 1'b1;
          state_q <= last_word ? S_FLUSH : S_RREQ;
        end
        S_FLUSH: if (flush_ack) state_q <= S_WRITE;
        S_WRITE: if (wr_ready)  state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (state_q == S_IDLE);
  assign rd_req_valid = (state_q == S_RREQ);
  assign rd_req_addr  = base_q + (AW'(cnt_q) << OFF_W);
  assign flush_req    = (state_q == S_FLUSH);
  assign wr_valid     = (state_q == S_WRITE);
  assign dst_addr     = dst_q;
  assign src_off      = off_q;
  assign g_clear      = take;
  assign g_push       = (state_q == S_RWAIT) && rd_rsp_valid;
  assign g_stage      = (state_q == S_FLUSH);
  assign done         = (state_q == S_DONE);
  assign status       = stat_q;

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready) else $error("ready while busy"); // R1
  AST_WR_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> dst_addr[LOFF_W-1:0] == '0) else $error("misaligned write"); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> rd_req_valid && $stable(rd_req_addr)) else $error("read dropped"); // R8
  AST_RD_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[OFF_W-1:0] == '0) else $error("unaligned read"); // R4
  AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> flush_req) else $error("flush dropped"); // R6
  AST_WR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(flush_req && flush_ack)) else $error("write before flush ack"); // R6
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, flush_req, wr_valid})) else $error("phases overlap"); // R7
  AST_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_valid) else $error("second beat"); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready) else $error("done not a pulse"); // R9
endmodule

// File: rtl/dline_copy.sv
module dline_copy #(
  parameter int AW         = 48,
  parameter int WORD_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [AW-1:0]           cmd_src,
  input  logic [AW-1:0]           cmd_dst,
  input  logic                    cmd_lock,
  output logic                    rd_req_valid,
  input  logic                    rd_req_ready,
  output logic [AW-1:0]           rd_req_addr,
  input  logic                    rd_rsp_valid,
  input  logic [WORD_W-1:0]       rd_rsp_data,
  output logic                    flush_req,
  output logic [AW-1:0]           flush_addr,
  input  logic                    flush_ack,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [AW-1:0]           wr_addr,
  output logic [LINE_BYTES*8-1:0] wr_data,
  output logic [LINE_BYTES-1:0]   wr_be,
  output logic                    wr_alloc,
  output logic                    done,
  output logic [1:0]              status
);
  localparam int OFF_W = $clog2(WORD_W / 8);

  logic [AW-1:0]    dst_addr;
  logic [OFF_W-1:0] src_off;
  logic             g_clear;
  logic             g_push;
  logic             g_stage;

  dlc_ctrl #(.AW(AW), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_src      (cmd_src),
    .cmd_dst      (cmd_dst),
    .cmd_lock     (cmd_lock),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .flush_req    (flush_req),
    .flush_ack    (flush_ack),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .dst_addr     (dst_addr),
    .src_off      (src_off),
    .g_clear      (g_clear),
    .g_push       (g_push),
    .g_stage      (g_stage),
    .done         (done),
    .status       (status)
  );

  dlc_gather #(.WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES)) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (g_clear),
    .push      (g_push),
    .push_data (rd_rsp_data),
    .byte_off  (src_off),
    .stage_ld  (g_stage),
    .line      (wr_data)
  );

  assign flush_addr = dst_addr;
  assign wr_addr    = dst_addr;
  assign wr_be      = '1;
  assign wr_alloc   = 1'b0;

  AST_WR_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_data) && $stable(wr_addr)) else $error("write payload moved"); // R8
endmodule

// File: tb/dline_copy_tb.sv
`timescale 1ns/1ps
module dline_copy_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [47:0]  cmd_src = '0;
  logic [47:0]  cmd_dst = '0;
  logic         cmd_lock = 1'b0;
  logic         rd_req_valid;
  logic         rd_req_ready = 1'b0;
  logic [47:0]  rd_req_addr;
  logic         rd_rsp_valid = 1'b0;
  logic [63:0]  rd_rsp_data = '0;
  logic         flush_req;
  logic [47:0]  flush_addr;
  logic         flush_ack = 1'b0;
  logic         wr_valid;
  logic         wr_ready = 1'b0;
  logic [47:0]  wr_addr;
  logic [511:0] wr_data;
  logic [63:0]  wr_be;
  logic         wr_alloc;
  logic         done;
  logic [1:0]   status;

  always #2 clk = ~clk;

  dline_copy u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit stall = 0;
  int fl_delay = 0;
  int n_rd, n_fl, n_wr, n_done, seq_err, hold_err, order_err, traffic;
  logic [47:0]  exp_base, fl_addr_c, wr_addr_c;
  logic [511:0] wr_data_c, wr_prev;
  logic [63:0]  wr_be_c;
  logic         wr_alloc_c;
  logic [1:0]   st_c;
  logic         ready_busy;

  function automatic logic [7:0] memb(input logic [47:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hC3;
  endfunction

  function automatic logic [63:0] memw(input logic [47:0] a);
    logic [63:0] w;
    for (int j = 0; j < 8; j++) w[8*j +: 8] = memb(a + 48'(j));
    return w;
  endfunction

  function automatic logic [511:0] exp_line(input logic [47:0] s);
    logic [511:0] l;
    for (int k = 0; k < 64; k++) l[8*k +: 8] = memb(s + 48'(k));
    return l;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // responders and monitors, sampling one ns after the rising edge
  initial begin
    bit pend = 0;
    logic [47:0] pend_a = '0;
    int ctr = 0, flw = 0;
    bit prev_v = 0;
    forever begin
      @(posedge clk); #1;
      ctr++;
      rd_rsp_valid = 1'b0;
      if (pend) begin rd_rsp_valid = 1'b1; rd_rsp_data = memw(pend_a); pend = 0; end
      rd_req_ready = stall ? (ctr % 3 == 2) : 1'b1;
      if (rd_req_valid && rd_req_ready) begin
        if (rd_req_addr != exp_base + 48'(8 * n_rd)) seq_err++;
        n_rd++; pend = 1; pend_a = rd_req_addr;
      end
      flush_ack = 1'b0;
      if (flush_req) begin
        if (flw >= fl_delay) begin flush_ack = 1'b1; n_fl++; fl_addr_c = flush_addr; flw = 0; end
        else flw++;
      end
      if (wr_valid && n_fl == 0) order_err++;
      if (rd_req_valid || flush_req || wr_valid) traffic++;
      wr_ready = stall ? (ctr % 4 == 3) : 1'b1;
      if (wr_valid && prev_v && wr_data != wr_prev) hold_err++;
      if (wr_valid && wr_ready) begin
        n_wr++; wr_data_c = wr_data; wr_addr_c = wr_addr; wr_be_c = wr_be; wr_alloc_c = wr_alloc;
      end
      prev_v = wr_valid && !wr_ready;
      wr_prev = wr_data;
      if (done) begin n_done++; st_c = status; end
    end
  end

  task automatic run_cmd(input logic [47:0] s, input logic [47:0] d, input bit l);
    n_rd = 0; n_fl = 0; n_wr = 0; n_done = 0; seq_err = 0; hold_err = 0; order_err = 0; traffic = 0;
    exp_base = {s[47:3], 3'b000};
    @(negedge clk);
    cmd_valid = 1'b1; cmd_src = s; cmd_dst = d; cmd_lock = l;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    ready_busy = cmd_ready;
    for (int w = 0; w < 2000 && n_done == 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_ok(input logic [47:0] s, input logic [47:0] d, input string nm);
    run_cmd(s, d, 1'b0);
    chk(ready_busy == 1'b0, {"R1 busy ", nm}, 512'(ready_busy), 512'(0));
    chk(n_done == 1 && st_c == 2'd0, {"R9 done/status ", nm}, 512'(st_c), 512'(0));
    chk(n_rd == ((s[2:0] != 0) ? 9 : 8), {"R4 read count ", nm}, 512'(n_rd), 512'((s[2:0] != 0) ? 9 : 8));
    chk(seq_err == 0, {"R4 read addresses ", nm}, 512'(seq_err), 512'(0));
    chk(n_fl == 1 && fl_addr_c == d, {"R6 flush ", nm}, 512'(fl_addr_c), 512'(d));
    chk(order_err == 0, {"R6 order ", nm}, 512'(order_err), 512'(0));
    chk(n_wr == 1 && wr_addr_c == d, {"R7 one beat ", nm}, 512'(wr_addr_c), 512'(d));
    chk(wr_be_c == '1 && wr_alloc_c == 1'b0, {"R7 be/alloc ", nm}, 512'({wr_alloc_c, wr_be_c}), 512'({1'b0, 64'hFFFF_FFFF_FFFF_FFFF}));
    chk(wr_data_c == exp_line(s), {"R5 data ", nm}, wr_data_c, exp_line(s));
    chk(hold_err == 0, {"R8 write hold ", nm}, 512'(hold_err), 512'(0));
  endtask

  task automatic t_reset;
    chk(cmd_ready == 1'b1, "R1 reset ready", 512'(cmd_ready), 512'(1));
    chk(!rd_req_valid && !flush_req && !wr_valid, "R7 reset idle ports", 512'({rd_req_valid, flush_req, wr_valid}), 512'(0));
    chk(done == 1'b0, "R9 reset done", 512'(done), 512'(0));
  endtask

  task automatic t_fault(input logic [47:0] d, input bit l, input logic [1:0] exp_st, input string tag);
    run_cmd(48'h0000_9003, d, l);
    chk(n_done == 1 && st_c == exp_st, {tag, " status"}, 512'(st_c), 512'(exp_st));
    chk(traffic == 0, {tag, " no traffic"}, 512'(traffic), 512'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    check_ok(48'h0000_1000, 48'h0000_2040, "aligned");
    check_ok(48'h0000_3105, 48'h0000_4000, "offset5");
    stall = 1; fl_delay = 5;
    check_ok(48'h0000_51F7, 48'h0000_6080, "stalled offset7");
    stall = 0; fl_delay = 0;
    t_fault(48'h0000_5004, 1'b0, 2'd1, "R2 misaligned");
    t_fault(48'h0000_5020, 1'b0, 2'd1, "R2 misaligned bit5");
    t_fault(48'h0000_5004, 1'b1, 2'd2, "R3 lock over misaligned");
    t_fault(48'h0000_5000, 1'b1, 2'd2, "R3 lock aligned");
    check_ok(48'h0000_7FF9, 48'h0000_7FC0, "after faults");
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired R9 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule